// File: doc/BRIEF.md
# Combined Explicit Inversive Random Generator

This block produces uniform pseudorandom fractions from three explicit inversive congruential components. Each component has a prime modulus just under 2^24. Every output is a pure function of a pixel position and a per-component index, and never of an earlier output. Any number of positions can therefore be evaluated independently, in any order, with no stored stream state.

A request presents a 12-bit column `px`, a 12-bit row `py`, three component indices and a lane mode, then pulses `start`. For each lane and each component, the block builds an index from the position and the counter. It inverts that index modulo the prime on a shared binary extended-GCD unit, applies a small affine map, and scales the result to a 24-bit fraction. The three fractions of a lane are summed modulo one.

The scalar mode yields one value. The four-lane mode yields four values, taken from consecutive indices. The block also returns the advanced counters that the caller feeds into its next request.

The controller has five states:
- `G_IDLE` waits for `start`.
- `G_LOAD` launches an inversion.
- `G_WAIT` holds until the inverter finishes.
- `G_ACCUM` adds the component fraction, then moves to the next component or lane.
- `G_FINISH` lasts one cycle and raises `done`.

The transitions are:
- accept: `G_IDLE` or `G_FINISH` to `G_LOAD`, when `start` is high.
- launch: `G_LOAD` to `G_WAIT`.
- inverted: `G_WAIT` to `G_ACCUM`.
- next-item: `G_ACCUM` to `G_LOAD`.
- last-item: `G_ACCUM` to `G_FINISH`.
- retire: `G_FINISH` to `G_IDLE`, when `start` is low.

The inverter has three states: `I_IDLE`, `I_RUN` and `I_DONE`.

Top module: `eicg_gen`

## Requirements
- R1: For component k, the block forms idx = ((((x + 4096·y) mod m_k)·B_k) + ((n_k + L) mod m_k)) mod m_k, where L is the lane number. It then forms t_k = (a_k·inv(idx) + c_k) mod m_k. The constants (m, a, B, c) are (16777213, 7, 24, 0) for k = 0, (16777199, 11, 1753, 0) for k = 1 and (16777183, 13, 3969, 0) for k = 2. The value inv(s) satisfies s·inv(s) ≡ 1 mod m_k.
- R2: The inverse of a zero index is zero, so a zero index makes that component contribute 0.
- R3: The value of a lane is (Σ_k floor(t_k·2^24 / m_k)) mod 2^24, given as a 24-bit unsigned fraction of one.
- R4: In scalar mode (`quad` = 0), lane 0 carries the result in `rnd[23:0]` and `rnd[95:24]` reads zero.
- R5: In four-lane mode (`quad` = 1), lane L uses index offset L and sits at `rnd[24L+23:24L]`, for L = 0 to 3. The offset wraps modulo m_k.
- R6: At `done`, `cnt_next{k}` equals (n_k + 1) mod m_k in scalar mode and (n_k + 4) mod m_k in four-lane mode.
- R7: `done` is high for exactly one cycle per accepted request. `busy` is high from the cycle after acceptance until `done` rises.
- R8: A `start` while `busy` is high is ignored. All inputs are sampled only at an accepted `start`.
- R9: A `start` in the same cycle as `done` is accepted and begins a new request.
- R10: After reset, `busy`, `done`, `rnd` and all `cnt_next{k}` are zero.
- R11: One inversion takes at most 4·24+4 iteration cycles. A request finishes within lanes·3·(4·24+12) cycles of acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe |
| quad | input | 1 | 1 selects four-lane mode |
| px | input | 12 | Pixel column |
| py | input | 12 | Pixel row |
| cnt0 | input | 24 | Index of component 0, below 16777213 |
| cnt1 | input | 24 | Index of component 1, below 16777199 |
| cnt2 | input | 24 | Index of component 2, below 16777183 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rnd | output | 96 | Lane fractions, lane L at bits 24L+23:24L |
| cnt_next0 | output | 24 | Advanced index of component 0 |
| cnt_next1 | output | 24 | Advanced index of component 1 |
| cnt_next2 | output | 24 | Advanced index of component 2 |

## Verification
Completion of one request and acceptance of the next can fall in the same cycle. This happens because `G_FINISH` both raises `done` and listens to `start`. The bench provokes this by watching for `done` at a falling edge and driving a new `start`, with new operands, at that same edge. It judges the overlap in three ways. The first result must be intact while `done` is high. `busy` must be high one cycle later. The second result and its advanced counters must match the reference computed for the new operands.

// File: rtl/eicg_pkg.sv
package eicg_pkg;

    localparam int W       = 24;
    localparam int XW      = 12;
    localparam int NCOMP   = 3;
    localparam int NLANE   = 4;
    localparam int CW      = $clog2(NCOMP);
    localparam int LW      = $clog2(NLANE);
    localparam int INV_MAX = 4 * W + 4;
    localparam int STEP_W  = $clog2(INV_MAX + 2);

    typedef logic [W-1:0]   word_t;
    typedef logic [2*W-1:0] dword_t;

    typedef struct packed {
        word_t modulus;
        word_t mult;
        word_t scale;
        word_t incr;
    } comp_cfg_t;

    function automatic comp_cfg_t comp_cfg(input logic [CW-1:0] k);
        comp_cfg_t c;
        unique case (k)
            CW'(0):  c = '{modulus: W'(16777213), mult: W'(7),  scale: W'(24),   incr: '0};
            CW'(1):  c = '{modulus: W'(16777199), mult: W'(11), scale: W'(1753), incr: '0};
            default: c = '{modulus: W'(16777183), mult: W'(13), scale: W'(3969), incr: '0};
        endcase
        return c;
    endfunction

    // Reduction for a modulus just below 2^W: fold the high part back
    // in with weight 2^W - m, three times, then one conditional subtract.
    function automatic word_t fold(input dword_t v, input word_t m);
        dword_t d;
        dword_t lo_mask;
        dword_t t;
        d       = (dword_t'(1) << W) - dword_t'(m);
        lo_mask = (dword_t'(1) << W) - dword_t'(1);
        t       = v;
        for (int i = 0; i < 3; i++) begin
            t = ((t >> W) * d) + (t & lo_mask);
        end
        if (t >= dword_t'(m)) begin
            t = t - dword_t'(m);
        end
        return t[W-1:0];
    endfunction

    function automatic word_t addmod(input word_t a, input word_t b, input word_t m);
        logic [W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, m}) begin
            s = s - {1'b0, m};
        end
        return s[W-1:0];
    endfunction

endpackage

// File: rtl/eicg_index.sv
module eicg_index
    import eicg_pkg::*;
(
    input  logic [XW-1:0] px,
    input  logic [XW-1:0] py,
    input  word_t         cnt,
    input  logic [LW-1:0] lane,
    input  word_t         modulus,
    input  word_t         scale,
    output word_t         idx
);

    word_t pos_r;
    word_t scaled;
    word_t cnt_l;

    always_comb begin
        pos_r  = fold((dword_t'(py) << XW) | dword_t'(px), modulus);
        scaled = fold(dword_t'(pos_r) * dword_t'(scale), modulus);
        cnt_l  = addmod(cnt, word_t'(lane), modulus);
        idx    = addmod(scaled, cnt_l, modulus);
    end

endmodule

// File: rtl/eicg_frac.sv
module eicg_frac
    import eicg_pkg::*;
(
    input  word_t inv,
    input  word_t mult,
    input  word_t incr,
    input  word_t modulus,
    output word_t frac
);

    word_t  t;
    word_t  d;
    dword_t sd;
    dword_t q0;
    dword_t rem;
    dword_t q;

    // frac = floor(t * 2^W / m) = t + floor(t * d / m), with d = 2^W - m
    always_comb begin
        t   = addmod(fold(dword_t'(mult) * dword_t'(inv), modulus), incr, modulus);
        d   = word_t'((dword_t'(1) << W) - dword_t'(modulus));
        sd  = dword_t'(t) * dword_t'(d);
        q0  = sd >> W;
        rem = sd - q0 * dword_t'(modulus);
        q   = (rem >= dword_t'(modulus)) ? q0 + dword_t'(1) : q0;
        frac = t + q[W-1:0];
    end

endmodule

// File: rtl/eicg_modinv.sv
module eicg_modinv
    import eicg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  go,
    input  word_t operand,
    input  word_t modulus,
    output logic  busy,
    output logic  done,
    output word_t result
);

    typedef enum logic [1:0] {I_IDLE, I_RUN, I_DONE} inv_state_e;

    inv_state_e        st, st_nx;
    word_t             u, v, x1, x2, m_q, op_q;
    logic [STEP_W-1:0] steps;

    function automatic word_t half_mod(input word_t x, input word_t m);
        logic [W:0] s;
        s = x[0] ? ({1'b0, x} + {1'b0, m}) : {1'b0, x};
        return s[W:1];
    endfunction

    function automatic word_t sub_mod(input word_t a, input word_t b, input word_t m);
        logic [W:0] s;
        s = (a >= b) ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, m} - {1'b0, b});
        return s[W-1:0];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= I_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            I_IDLE: if (go) st_nx = (operand == '0) ? I_DONE : I_RUN;
            I_RUN:  if (u == W'(1) || v == W'(1)) st_nx = I_DONE;
            I_DONE: st_nx = I_IDLE;
            default: st_nx = I_IDLE;
        endcase
    end

    always_comb begin
        busy = (st != I_IDLE);
        done = (st == I_DONE);
    end

    // Invariants: x1*op = u and x2*op = v (mod m)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u <= '0; v <= '0; x1 <= '0; x2 <= '0;
            m_q <= '0; op_q <= '0; result <= '0; steps <= '0;
        end else begin
            unique case (st)
                I_IDLE: if (go) begin
                    m_q   <= modulus;
                    op_q  <= operand;
                    u     <= operand;
                    v     <= modulus;
                    x1    <= W'(1);
                    x2    <= '0;
                    steps <= '0;
                    if (operand == '0) result <= '0;
                end
                I_RUN: begin
                    steps <= steps + STEP_W'(1);
                    if (u == W'(1)) begin
                        result <= x1;
                    end else if (v == W'(1)) begin
                        result <= x2;
                    end else if (!u[0]) begin
                        u  <= u >> 1;
                        x1 <= half_mod(x1, m_q);
                    end else if (!v[0]) begin
                        v  <= v >> 1;
                        x2 <= half_mod(x2, m_q);
                    end else if (u >= v) begin
                        u  <= u - v;
                        x1 <= sub_mod(x1, x2, m_q);
                    end else begin
                        v  <= v - u;
                        x2 <= sub_mod(x2, x1, m_q);
                    end
                end
                default: ;
            endcase
        end
    end

    p_inv_steps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == I_RUN) |-> (steps <= STEP_W'(INV_MAX)));

    p_inv_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q != '0) |->
        ((dword_t'(result) * dword_t'(op_q)) % dword_t'(m_q) == dword_t'(1)));

    p_inv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == '0) |-> (result == '0));

endmodule

// File: rtl/eicg_gen.sv
module eicg_gen
    import eicg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                quad,
    input  logic [XW-1:0]       px,
    input  logic [XW-1:0]       py,
    input  logic [W-1:0]        cnt0,
    input  logic [W-1:0]        cnt1,
    input  logic [W-1:0]        cnt2,
    output logic                busy,
    output logic                done,
    output logic [NLANE*W-1:0]  rnd,
    output logic [W-1:0]        cnt_next0,
    output logic [W-1:0]        cnt_next1,
    output logic [W-1:0]        cnt_next2
);

    typedef enum logic [2:0] {G_IDLE, G_LOAD, G_WAIT, G_ACCUM, G_FINISH} gen_state_e;

    gen_state_e    st, st_nx;
    logic [XW-1:0] cap_px, cap_py;
    logic          cap_quad;
    word_t         cap_n [NCOMP];
    word_t         in_n  [NCOMP];
    word_t         step_n[NCOMP];
    word_t         nxt   [NCOMP];
    logic [CW-1:0] comp;
    logic [LW-1:0] lane;
    logic [LW-1:0] last_lane;
    word_t         acc, inv_q, cur_n, idx, frac, inv_res, sum;
    comp_cfg_t     cfg;
    logic          accept, inv_go, inv_busy, inv_done;

    assign in_n[0] = cnt0;
    assign in_n[1] = cnt1;
    assign in_n[2] = cnt2;

    always_comb begin
        cfg   = comp_cfg(comp);
        cur_n = cap_n[0];
        for (int k = 0; k < NCOMP; k++) begin
            if (comp == CW'(k)) cur_n = cap_n[k];
        end
        last_lane = cap_quad ? LW'(NLANE - 1) : '0;
        accept    = start && (st == G_IDLE || st == G_FINISH);
        sum       = acc + frac;
    end

    eicg_index i_index (
        .px(cap_px), .py(cap_py), .cnt(cur_n), .lane(lane),
        .modulus(cfg.modulus), .scale(cfg.scale), .idx(idx)
    );

    eicg_modinv i_inv (
        .clk(clk), .rst_n(rst_n), .go(inv_go), .operand(idx),
        .modulus(cfg.modulus), .busy(inv_busy), .done(inv_done), .result(inv_res)
    );

    eicg_frac i_frac (
        .inv(inv_q), .mult(cfg.mult), .incr(cfg.incr),
        .modulus(cfg.modulus), .frac(frac)
    );

    for (genvar k = 0; k < NCOMP; k++) begin : g_step
        comp_cfg_t kc;
        assign kc = comp_cfg(CW'(k));
        assign step_n[k] = addmod(cap_n[k], cap_quad ? W'(NLANE) : W'(1), kc.modulus);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= G_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            G_IDLE:   if (accept) st_nx = G_LOAD;
            G_LOAD:   st_nx = G_WAIT;
            G_WAIT:   if (inv_done) st_nx = G_ACCUM;
            G_ACCUM:  st_nx = (comp == CW'(NCOMP - 1) && lane == last_lane) ? G_FINISH : G_LOAD;
            G_FINISH: st_nx = accept ? G_LOAD : G_IDLE;
            default:  st_nx = G_IDLE;
        endcase
    end

    always_comb begin
        busy   = !(st == G_IDLE || st == G_FINISH);
        done   = (st == G_FINISH);
        inv_go = (st == G_LOAD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_px <= '0; cap_py <= '0; cap_quad <= 1'b0;
            comp <= '0; lane <= '0; acc <= '0; inv_q <= '0; rnd <= '0;
            for (int k = 0; k < NCOMP; k++) begin
                cap_n[k] <= '0;
                nxt[k]   <= '0;
            end
        end else begin
            if (accept) begin
                cap_px   <= px;
                cap_py   <= py;
                cap_quad <= quad;
                for (int k = 0; k < NCOMP; k++) cap_n[k] <= in_n[k];
                comp <= '0;
                lane <= '0;
                acc  <= '0;
                rnd  <= '0;
            end else if (st == G_WAIT && inv_done) begin
                inv_q <= inv_res;
            end else if (st == G_ACCUM) begin
                if (comp == CW'(NCOMP - 1)) begin
                    rnd[lane*W +: W] <= sum;
                    acc  <= '0;
                    comp <= '0;
                    if (lane == last_lane) begin
                        for (int k = 0; k < NCOMP; k++) nxt[k] <= step_n[k];
                    end else begin
                        lane <= lane + LW'(1);
                    end
                end else begin
                    acc  <= sum;
                    comp <= comp + CW'(1);
                end
            end
        end
    end

    assign cnt_next0 = nxt[0];
    assign cnt_next1 = nxt[1];
    assign cnt_next2 = nxt[2];

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ($stable(cap_px) && $stable(cap_py) && $stable(cap_quad)));

    p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == G_LOAD) |-> (idx < cfg.modulus));

    p_inv_idle_on_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == G_LOAD) |-> !inv_busy);

    p_scalar_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_quad) |-> (rnd[NLANE*W-1:W] == '0));

    p_next_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_next0 < W'(16777213) && cnt_next1 < W'(16777199) && cnt_next2 < W'(16777183)));

endmodule

// File: tb/test_eicg_gen.sv
`timescale 1ns/1ps
module test_eicg_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        quad = 1'b0;
    logic [11:0] px = '0, py = '0;
    logic [23:0] cnt0 = '0, cnt1 = '0, cnt2 = '0;
    logic        busy, done;
    logic [95:0] rnd;
    logic [23:0] cnt_next0, cnt_next1, cnt_next2;

    int n_chk = 0;
    int n_bad = 0;

    localparam longint LIM1 = 3 * (4 * 24 + 12);

    always #2.5 clk = ~clk;

    eicg_gen i_eicg_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .quad(quad), .px(px), .py(py),
        .cnt0(cnt0), .cnt1(cnt1), .cnt2(cnt2), .busy(busy), .done(done), .rnd(rnd),
        .cnt_next0(cnt_next0), .cnt_next1(cnt_next1), .cnt_next2(cnt_next2)
    );

    function automatic longint mod_of(int k);
        return (k == 0) ? 64'd16777213 : (k == 1) ? 64'd16777199 : 64'd16777183;
    endfunction
    function automatic longint mul_of(int k);
        return (k == 0) ? 64'd7 : (k == 1) ? 64'd11 : 64'd13;
    endfunction
    function automatic longint scl_of(int k);
        return (k == 0) ? 64'd24 : (k == 1) ? 64'd1753 : 64'd3969;
    endfunction

    function automatic longint modpow(longint b, longint e, longint m);
        longint r = 1;
        longint bb = b % m;
        while (e > 0) begin
            if (e[0]) r = (r * bb) % m;
            bb = (bb * bb) % m;
            e = e >> 1;
        end
        return r;
    endfunction

    function automatic longint ref_lane(longint x, longint y, longint n0, longint n1,
                                        longint n2, longint l);
        longint acc = 0;
        for (int k = 0; k < 3; k++) begin
            longint m = mod_of(k);
            longint n = (k == 0) ? n0 : (k == 1) ? n1 : n2;
            longint s = (x + 4096 * y) % m;
            s = (s * scl_of(k)) % m;
            s = (s + ((n + l) % m)) % m;
            s = (s == 0) ? 0 : modpow(s, m - 2, m);
            s = (mul_of(k) * s) % m;
            acc = acc + ((s << 24) / m);
        end
        return acc & 64'hFFFFFF;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic launch(longint x, longint y, longint n0, longint n1, longint n2, bit q);
        px = 12'(x); py = 12'(y); cnt0 = 24'(n0); cnt1 = 24'(n1); cnt2 = 24'(n2);
        quad = q; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output longint cyc);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic check_out(longint x, longint y, longint n0, longint n1, longint n2,
                             bit q, string tag);
        longint st = q ? 4 : 1;
        chk({tag, " R7 done seen"}, longint'(done), 1);
        for (int l = 0; l < 4; l++) begin
            if (l < (q ? 4 : 1))
                chk({tag, " R1 R3 R5 lane value"}, longint'(rnd[24*l +: 24]),
                    ref_lane(x, y, n0, n1, n2, l));
            else
                chk({tag, " R4 unused lane zero"}, longint'(rnd[24*l +: 24]), 0);
        end
        chk({tag, " R6 next0"}, longint'(cnt_next0), (n0 + st) % mod_of(0));
        chk({tag, " R6 next1"}, longint'(cnt_next1), (n1 + st) % mod_of(1));
        chk({tag, " R6 next2"}, longint'(cnt_next2), (n2 + st) % mod_of(2));
    endtask

    task automatic do_run(longint x, longint y, longint n0, longint n1, longint n2,
                          bit q, string tag);
        longint cyc;
        launch(x, y, n0, n1, n2, q);
        chk({tag, " R7 busy after start"}, longint'(busy), 1);
        wait_done(cyc);
        chk({tag, " R11 latency bound"}, longint'(cyc <= (q ? 4 : 1) * LIM1), 1);
        check_out(x, y, n0, n1, n2, q, tag);
        @(negedge clk);
        chk({tag, " R7 done one cycle"}, longint'(done), 0);
        chk({tag, " R7 idle after done"}, longint'(busy), 0);
    endtask

    task automatic t_reset;
        chk("R10 busy", longint'(busy), 0);
        chk("R10 done", longint'(done), 0);
        chk("R10 rnd", longint'(rnd == '0), 1);
        chk("R10 next", longint'(cnt_next0 | cnt_next1 | cnt_next2), 0);
    endtask

    task automatic t_scalar;
        do_run(5, 7, 100, 200, 300, 1'b0, "scalar-a");
        do_run(4095, 4095, 12345, 999, 16777000, 1'b0, "scalar-max");
        do_run(1234, 567, 16777212, 16777198, 16777182, 1'b0, "scalar-top");
    endtask

    task automatic t_zero;
        // R2: all indices zero gives output zero
        do_run(0, 0, 0, 0, 0, 1'b0, "zero-all");
        chk("R2 zero output", longint'(rnd[23:0]), 0);
        // R2: only component 0 zero
        do_run(0, 0, 0, 5, 9, 1'b0, "zero-one");
    endtask

    task automatic t_quad;
        do_run(17, 3000, 40, 50, 60, 1'b1, "quad-a");
        // R5 wrap: offsets cross the modulus
        do_run(2048, 1, 16777211, 16777197, 16777181, 1'b1, "quad-wrap");
    endtask

    task automatic t_ignore;
        longint cyc;
        launch(300, 400, 7, 8, 9, 1'b0);
        repeat (5) @(negedge clk);
        // R8: different operands while busy
        px = 12'd1; py = 12'd2; cnt0 = 24'd3; quad = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        check_out(300, 400, 7, 8, 9, 1'b0, "ignore R8");
        @(negedge clk);
        chk("R8 no second run", longint'(busy), 0);
    endtask

    task automatic t_b2b;
        longint cyc;
        launch(11, 22, 33, 44, 55, 1'b0);
        wait_done(cyc);
        check_out(11, 22, 33, 44, 55, 1'b0, "b2b-first R9");
        launch(99, 88, 77, 66, 55, 1'b1);
        chk("R9 accepted in done cycle", longint'(busy), 1);
        wait_done(cyc);
        check_out(99, 88, 77, 66, 55, 1'b1, "b2b-second R9");
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scalar();
        t_zero();
        t_quad();
        t_ignore();
        t_b2b();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule